// File: doc/BRIEF.md
# Redundant Clock Failover Selector

This block takes two reference clocks and passes one of them to a single clock output. A static select input decides which reference is the primary. Each reference is watched by an activity monitor that runs on a separate free-running detection clock. When the primary stops toggling, the output moves to the other reference. Every change of source, whether forced by a loss or requested by the user, goes through an enable handshake and leaves no short pulse on the output.

A primary that comes back is not taken again at once. The block first counts a fixed number of its rising edges while it stays present without a break. A dropout during that count starts the count again from zero. When neither reference is alive, the output is parked low and a flag reports that no clock is available. The status outputs are synchronous to the detection clock.

The detection clock must run more than twice as fast as either reference. The loss window, given in detection cycles, must be longer than the slower reference's period.

Top module: `clk_failover_sel`

## Requirements
- R1: While reset is asserted, `clk_out` is low, `no_clock` is high, and `primary_present` and `secondary_present` are low.
- R2: `pri_sel` = 0 makes `ref_a` the primary and `pri_sel` = 1 makes `ref_b` the primary. With both references running, `clk_out` carries the primary's period and `active_is_a` is 1 exactly when `ref_a` is the selected source.
- R3: A reference that shows no rising edge for `LOSS_WIN` detection cycles is reported absent, and its next edge reports it present again. `primary_present` reflects the input nominated by `pri_sel` and `secondary_present` reflects the other input.
- R4: When the primary is absent and the secondary is present, the selection moves to the secondary in the next detection cycle. `clk_out` then carries the secondary's period.
- R5: `clk_out` never shows a high or low pulse shorter than the shorter half-period of the two references, and the two source enables are never on together.
- R6: After a lost primary returns, it is selected again only once `REQUAL_CNT` (default 1024) of its rising edges have been counted while it stays present, provided the secondary is present.
- R7: If the returning primary drops out again before the count completes, the count restarts from zero and the output stays on the secondary.
- R8: A change of `pri_sel` while both references run moves the output to the newly nominated primary at once, with no qualification count.
- R9: When both references are absent, `no_clock` is high, both enables are cleared without waiting for a handshake, and `clk_out` stays low.
- R10: Loss of the secondary while the primary is selected leaves `clk_out` and `active_is_a` unchanged and drives `secondary_present` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| det_clk | input | 1 | Free-running detection clock; all status outputs are synchronous to it |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_a | input | 1 | Reference clock A |
| ref_b | input | 1 | Reference clock B |
| pri_sel | input | 1 | Primary nomination: 0 selects A, 1 selects B |
| clk_out | output | 1 | Selected clock |
| active_is_a | output | 1 | 1 when reference A is the selected source |
| primary_present | output | 1 | The nominated primary is toggling |
| secondary_present | output | 1 | The other reference is toggling |
| no_clock | output | 1 | Neither reference is toggling |

## Verification
The selector is driven with both references running under each select value, which shows that the output follows the nomination (A at 100 ns, B at 140 ns). A loss of only the primary, as opposed to a loss of only the secondary, shows that failover is triggered by the right input. A primary that returns and runs without a break, compared with one that drops out partway through and then resumes, shows that the qualification count both gates the return and restarts on a dropout. The case with both references stopped checks that the output is parked low, and a pulse-width monitor running through every transition looks for runt pulses.

// File: rtl/cfs_pkg.sv
`timescale 1ns/1ps
package cfs_pkg;

  // Idle window expiry: the clock is declared lost once idle cycles fill the window.
  function automatic bit idle_expired(input int unsigned idle, input int unsigned win);
    return (idle + 1) >= win;
  endfunction

  // Qualification completes on the edge that brings the tally to the limit.
  function automatic bit requal_complete(input int unsigned tally, input int unsigned limit);
    return (tally + 1) >= limit;
  endfunction

  // Source choice: a qualified primary first, then a healthy secondary,
  // then an unqualified primary, and otherwise the previous choice.
  function automatic logic choose_a(input logic sel_b, input logic a_ok, input logic b_ok,
                                    input logic pri_qual, input logic cur_a);
    logic pri_ok;
    logic sec_ok;
    pri_ok = sel_b ? b_ok : a_ok;
    sec_ok = sel_b ? a_ok : b_ok;
    if (pri_ok && pri_qual) return ~sel_b;
    if (sec_ok)             return sel_b;
    if (pri_ok)             return ~sel_b;
    return cur_a;
  endfunction

endpackage

// File: rtl/cfs_activity_mon.sv
`timescale 1ns/1ps
module cfs_activity_mon #(
  parameter int unsigned LOSS_WIN    = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic det_clk,
  input  logic rst_n,
  input  logic mon_clk,
  output logic present,
  output logic edge_seen
);
  import cfs_pkg::*;

  localparam int unsigned CW = $clog2(LOSS_WIN + 1);

  logic                 toggle_q;
  logic [SYNC_STAGES:0] sync_q;
  logic [CW-1:0]        idle_q;

  // Toggle flop in the monitored domain: one change per rising edge.
  always_ff @(posedge mon_clk or negedge rst_n) begin
    if (!rst_n) toggle_q <= 1'b0;
    else        toggle_q <= ~toggle_q;
  end

  always_ff @(posedge det_clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-1:0], toggle_q};
  end

  assign edge_seen = sync_q[SYNC_STAGES] ^ sync_q[SYNC_STAGES-1];

  always_ff @(posedge det_clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q  <= '0;
      present <= 1'b0;
    end else if (edge_seen) begin
      idle_q  <= '0;
      present <= 1'b1;
    end else if (idle_expired(32'(idle_q), LOSS_WIN)) begin
      present <= 1'b0;
    end else begin
      idle_q  <= idle_q + CW'(1);
    end
  end

endmodule

// File: rtl/cfs_select_ctrl.sv
`timescale 1ns/1ps
module cfs_select_ctrl #(
  parameter int unsigned REQUAL_CNT  = 1024,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic det_clk,
  input  logic rst_n,
  input  logic pri_sel,
  input  logic a_pres,
  input  logic b_pres,
  input  logic a_edge,
  input  logic b_edge,
  output logic want_a,
  output logic qual,
  output logic sel_s,
  output logic sel_chg
);
  import cfs_pkg::*;

  localparam int unsigned CW = (REQUAL_CNT > 1) ? $clog2(REQUAL_CNT) : 1;

  logic [SYNC_STAGES-1:0] sel_sync_q;
  logic                   sel_q;
  logic                   pri_pres_q;
  logic [CW-1:0]          tally_q;
  logic                   prim_pres;
  logic                   prim_edge;

  always_ff @(posedge det_clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_sync_q <= '0;
      sel_q      <= 1'b0;
    end else begin
      sel_sync_q <= {sel_sync_q[SYNC_STAGES-2:0], pri_sel};
      sel_q      <= sel_sync_q[SYNC_STAGES-1];
    end
  end

  assign sel_s     = sel_sync_q[SYNC_STAGES-1];
  assign sel_chg   = sel_s ^ sel_q;
  assign prim_pres = sel_s ? b_pres : a_pres;
  assign prim_edge = sel_s ? b_edge : a_edge;

  // Qualification of a returning primary, counted on its own edges.
  always_ff @(posedge det_clk or negedge rst_n) begin
    if (!rst_n) begin
      qual       <= 1'b1;
      tally_q    <= '0;
      pri_pres_q <= 1'b0;
    end else begin
      pri_pres_q <= prim_pres;
      if (sel_chg) begin
        qual    <= 1'b1;
        tally_q <= '0;
      end else if (!prim_pres) begin
        tally_q <= '0;
        if (pri_pres_q) qual <= 1'b0;
      end else if (!qual && prim_edge) begin
        if (requal_complete(32'(tally_q), REQUAL_CNT)) begin
          qual    <= 1'b1;
          tally_q <= '0;
        end else begin
          tally_q <= tally_q + CW'(1);
        end
      end
    end
  end

  always_ff @(posedge det_clk or negedge rst_n) begin
    if (!rst_n) want_a <= 1'b1;
    else        want_a <= choose_a(sel_s, a_pres, b_pres, qual, want_a);
  end

endmodule

// File: rtl/cfs_glitchless_mux.sv
`timescale 1ns/1ps
module cfs_glitchless_mux #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned N_IN        = 2
) (
  input  logic            rst_n,
  input  logic [N_IN-1:0] clk_in,
  input  logic [N_IN-1:0] want,
  input  logic [N_IN-1:0] alive,
  output logic [N_IN-1:0] en,
  output logic            clk_out
);

  logic [N_IN-1:0] others_on;

  for (genvar i = 0; i < N_IN; i++) begin : g_branch
    logic [SYNC_STAGES-1:0] en_sh;
    logic                   clr_n;

    // A dead input cannot finish the handshake, so its loss clears the enable at once.
    assign clr_n        = rst_n & alive[i];
    assign others_on[i] = |(en & ~(N_IN'(1) << i));

    always_ff @(negedge clk_in[i] or negedge clr_n) begin
      if (!clr_n) en_sh <= '0;
      else        en_sh <= {en_sh[SYNC_STAGES-2:0], want[i] & ~others_on[i]};
    end

    assign en[i] = en_sh[SYNC_STAGES-1];
  end

  assign clk_out = |(clk_in & en);

endmodule

// File: rtl/clk_failover_sel.sv
`timescale 1ns/1ps
module clk_failover_sel #(
  parameter int unsigned LOSS_WIN    = 8,
  parameter int unsigned REQUAL_CNT  = 1024,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic det_clk,
  input  logic rst_n,
  input  logic ref_a,
  input  logic ref_b,
  input  logic pri_sel,
  output logic clk_out,
  output logic active_is_a,
  output logic primary_present,
  output logic secondary_present,
  output logic no_clock
);

  logic a_present_w, b_present_w;
  logic a_edge_w, b_edge_w;
  logic want_a_w, qual_w, sel_s_w, sel_chg_w;
  logic en_a_w, en_b_w;
  logic on_pri_w;
  logic [1:0] en_w;

  cfs_activity_mon #(.LOSS_WIN(LOSS_WIN), .SYNC_STAGES(SYNC_STAGES)) mon_a_i (
    .det_clk(det_clk), .rst_n(rst_n), .mon_clk(ref_a),
    .present(a_present_w), .edge_seen(a_edge_w)
  );

  cfs_activity_mon #(.LOSS_WIN(LOSS_WIN), .SYNC_STAGES(SYNC_STAGES)) mon_b_i (
    .det_clk(det_clk), .rst_n(rst_n), .mon_clk(ref_b),
    .present(b_present_w), .edge_seen(b_edge_w)
  );

  cfs_select_ctrl #(.REQUAL_CNT(REQUAL_CNT), .SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .det_clk(det_clk), .rst_n(rst_n), .pri_sel(pri_sel),
    .a_pres(a_present_w), .b_pres(b_present_w),
    .a_edge(a_edge_w), .b_edge(b_edge_w),
    .want_a(want_a_w), .qual(qual_w), .sel_s(sel_s_w), .sel_chg(sel_chg_w)
  );

  cfs_glitchless_mux #(.SYNC_STAGES(SYNC_STAGES), .N_IN(2)) mux_i (
    .rst_n(rst_n),
    .clk_in({ref_b, ref_a}),
    .want({~want_a_w, want_a_w}),
    .alive({b_present_w, a_present_w}),
    .en(en_w),
    .clk_out(clk_out)
  );

  assign en_a_w            = en_w[0];
  assign en_b_w            = en_w[1];
  assign on_pri_w          = want_a_w ^ sel_s_w;
  assign active_is_a       = want_a_w;
  assign primary_present   = sel_s_w ? b_present_w : a_present_w;
  assign secondary_present = sel_s_w ? a_present_w : b_present_w;
  assign no_clock          = ~(a_present_w | b_present_w);

endmodule

// File: rtl/cfs_checker.sv
`timescale 1ns/1ps
module cfs_checker (
  input logic det_clk,
  input logic rst_n,
  input logic sel_s,
  input logic sel_chg,
  input logic a_pres,
  input logic b_pres,
  input logic en_a,
  input logic en_b,
  input logic qual,
  input logic on_pri,
  input logic active_is_a,
  input logic primary_present,
  input logic secondary_present,
  input logic no_clock
);

  a_r5_single_enable: assert property (@(posedge det_clk) disable iff (!rst_n)
    !(en_a && en_b));

  a_r9_dead_a_disabled: assert property (@(posedge det_clk) disable iff (!rst_n)
    !a_pres |-> !en_a);

  a_r9_dead_b_disabled: assert property (@(posedge det_clk) disable iff (!rst_n)
    !b_pres |-> !en_b);

  a_r9_no_clock_dark: assert property (@(posedge det_clk) disable iff (!rst_n)
    no_clock |-> (!en_a && !en_b));

  a_r4_failover: assert property (@(posedge det_clk) disable iff (!rst_n)
    (!primary_present && secondary_present) |=> (active_is_a == $past(sel_s)));

  a_r6_return_qualified: assert property (@(posedge det_clk) disable iff (!rst_n)
    ($rose(on_pri) && !sel_chg && !$past(sel_chg) && $past(secondary_present))
      |-> $past(qual));

endmodule

bind clk_failover_sel cfs_checker chk_i (
  .det_clk(det_clk), .rst_n(rst_n), .sel_s(sel_s_w), .sel_chg(sel_chg_w),
  .a_pres(a_present_w), .b_pres(b_present_w), .en_a(en_a_w), .en_b(en_b_w),
  .qual(qual_w), .on_pri(on_pri_w), .active_is_a(active_is_a),
  .primary_present(primary_present), .secondary_present(secondary_present),
  .no_clock(no_clock)
);

// File: tb/clk_failover_sel_tb_top.sv
`timescale 1ns/1ps
module clk_failover_sel_tb_top;

  logic det_clk, rst_n, ref_a, ref_b, pri_sel;
  logic clk_out, active_is_a, primary_present, secondary_present, no_clock;
  bit   run_a, run_b;

  int   n_checks, n_fail, n_glitch, n_rise;
  time  t_last_rise, t_prev_rise, t_last_chg;

  clk_failover_sel dut_i (
    .det_clk(det_clk), .rst_n(rst_n), .ref_a(ref_a), .ref_b(ref_b), .pri_sel(pri_sel),
    .clk_out(clk_out), .active_is_a(active_is_a), .primary_present(primary_present),
    .secondary_present(secondary_present), .no_clock(no_clock)
  );

  // 50 MHz detection clock; reference edges are offset so they never meet its edges.
  initial begin det_clk = 1'b0; forever #10 det_clk = ~det_clk; end
  initial begin ref_a = 1'b0; #3; forever begin #50; ref_a = run_a ? ~ref_a : 1'b0; end end
  initial begin ref_b = 1'b0; #7; forever begin #70; ref_b = run_b ? ~ref_b : 1'b0; end end

  // Period and pulse-width observation of the output (R5).
  always @(posedge clk_out) begin
    t_prev_rise = t_last_rise;
    t_last_rise = $time;
    n_rise++;
  end
  always @(clk_out) begin
    if (rst_n && t_last_chg != 0 && ($time - t_last_chg) < 45) n_glitch++;
    t_last_chg = $time;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input string what, input longint act, input longint exp);
    chk(act == exp, req, what, act, exp);
  endtask

  function automatic longint period_now();
    return longint'(t_last_rise - t_prev_rise);
  endfunction

  task automatic t_reset();
    #200;
    chk_eq("R1", "clk_out", clk_out, 0);
    chk_eq("R1", "no_clock", no_clock, 1);
    chk_eq("R1", "primary_present", primary_present, 0);
    chk_eq("R1", "secondary_present", secondary_present, 0);
  endtask

  task automatic t_normal();
    run_a = 1; run_b = 1; pri_sel = 0;
    #100; rst_n = 1;
    #3000;
    chk_eq("R2", "active_is_a", active_is_a, 1);
    chk_eq("R2", "period A", period_now(), 100);
    chk_eq("R3", "primary_present", primary_present, 1);
    chk_eq("R3", "secondary_present", secondary_present, 1);
    chk_eq("R3", "no_clock", no_clock, 0);
  endtask

  task automatic t_sel_switch();
    pri_sel = 1; #3000;
    chk_eq("R8", "active_is_a after sel=1", active_is_a, 0);
    chk_eq("R8", "period B", period_now(), 140);
    pri_sel = 0; #3000;
    chk_eq("R8", "active_is_a after sel=0", active_is_a, 1);
    chk_eq("R2", "period A again", period_now(), 100);
  endtask

  task automatic t_sec_loss();
    run_b = 0; #2000;
    chk_eq("R10", "secondary_present", secondary_present, 0);
    chk_eq("R10", "active_is_a", active_is_a, 1);
    chk_eq("R10", "period A", period_now(), 100);
    run_b = 1; #2000;
    chk_eq("R3", "secondary_present back", secondary_present, 1);
  endtask

  task automatic t_failover_requal();
    run_a = 0; #2000;
    chk_eq("R3", "primary_present lost", primary_present, 0);
    chk_eq("R4", "active_is_a", active_is_a, 0);
    chk_eq("R4", "period B", period_now(), 140);
    run_a = 1; #100000;   // about 1000 primary cycles
    chk_eq("R6", "primary_present", primary_present, 1);
    chk_eq("R6", "still on B", active_is_a, 0);
    chk_eq("R6", "period B held", period_now(), 140);
    #8000;                // past 1024 cycles
    chk_eq("R6", "back on A", active_is_a, 1);
    chk_eq("R6", "period A", period_now(), 100);
  endtask

  task automatic t_dropout();
    run_a = 0; #2000;
    chk_eq("R4", "failover again", active_is_a, 0);
    run_a = 1; #80000;
    run_a = 0; #1000;
    run_a = 1; #80000;    // 1600 cycles total, 800 since the dropout
    chk_eq("R7", "count restarted", active_is_a, 0);
    chk_eq("R7", "period B", period_now(), 140);
    #30000;
    chk_eq("R7", "returns after full count", active_is_a, 1);
  endtask

  task automatic t_pri_b_loss_and_dark();
    int rises;
    pri_sel = 1; #3000;
    chk_eq("R8", "on B", active_is_a, 0);
    run_b = 0; #2000;
    chk_eq("R4", "fails over to A", active_is_a, 1);
    chk_eq("R3", "primary B absent", primary_present, 0);
    chk_eq("R4", "period A", period_now(), 100);
    run_a = 0; #2000;
    chk_eq("R9", "no_clock", no_clock, 1);
    rises = n_rise;
    #2000;
    chk_eq("R9", "clk_out low", clk_out, 0);
    chk_eq("R9", "no rising edges", n_rise - rises, 0);
    chk_eq("R5", "runt pulses", n_glitch, 0);
  endtask

  initial begin
    #2_000_000;
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; pri_sel = 0; run_a = 0; run_b = 0;
    t_reset();
    t_normal();
    t_sel_switch();
    t_sec_loss();
    t_failover_requal();
    t_dropout();
    t_pri_b_loss_and_dark();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule